// File: doc/BRIEF.md
# Local Programmable Interrupt Timer

This block is a down-counting interval timer for a local interrupt unit. A bus clock feeds a prescaler whose divisor is a power of two taken from a divide configuration register. The current count steps down once per divisor cycles, from a software-written initial count. When the count runs out, the block emits a one-cycle expiry strobe and adds one to a pending-expiry counter. In periodic mode the count reloads from the initial count and keeps running. In one-shot mode it stops at zero.

A timer entry register holds the interrupt vector, a mask bit, a delivery-status bit and the periodic-mode bit. A pending expiry is offered as an interrupt request carrying the vector only while the unit is enabled and the entry is unmasked. Each accepted request removes one pending expiry. Software accesses four 32-bit registers through a simple write port and a registered read port, addressed by byte offset.

Top module: `lpit_timer`

## Requirements
- R1: The divisor is 1 << ((({cfg[3], cfg[1], cfg[0]}) + 1) mod 8), and bit 2 of the divide configuration (offset 0xC) is ignored. Code 4'b1011 divides by 1, 4'b0000 by 2, 4'b0001 by 4, 4'b0011 by 16, 4'b1000 by 32, 4'b1001 by 64 and 4'b1010 by 128.
- R2: After an initial-count write of N, taken at clock edge E0, `expire_o` is high for one cycle after edge E0 + N*divisor.
- R3: Writing the initial count (offset 0x4) abandons any countdown in progress, loads the current count with the new value and clears the prescaler.
- R4: An initial count of zero leaves the timer stopped. No expiry occurs, and the current count reads zero.
- R5: With the periodic bit set, the count reloads on expiry and expires again every N*divisor cycles. With it clear, the timer expires once, then stays at zero with no further strobes.
- R6: A write to the divide configuration changes the divisor from the next prescaler comparison on, without restarting the count.
- R7: A read of offset 0x8 returns the number of whole divisor steps still left. Read data for any offset appears on `rd_data` one cycle after `rd_en`.
- R8: The timer entry (offset 0x0) keeps only vector bits [7:0], delivery status bit 12, mask bit 16 and periodic bit 17; all other bits read zero. It resets to 0x0001_0000, which is masked.
- R9: While `sw_enable` is low, the entry mask bit is forced to 1 and the pending count is held at zero. This includes an entry write made while `sw_enable` is low.
- R10: `irq_req` is high exactly when `hw_enable`, `sw_enable` and the unmasked entry all allow delivery and at least one expiry is pending. `irq_vector` carries the entry vector. A cycle with both `irq_req` and `irq_take` high removes one pending expiry.
- R11: The pending-expiry count saturates at 255 and does not wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| hw_enable | input | 1 | Unit hardware enable (gates delivery) |
| sw_enable | input | 1 | Unit software enable (low forces mask, clears pending) |
| wr_en | input | 1 | Register write strobe |
| wr_off | input | 4 | Write byte offset |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_off | input | 4 | Read byte offset |
| rd_data | output | 32 | Registered read data |
| irq_take | input | 1 | Request accepted this cycle |
| irq_req | output | 1 | Interrupt request |
| irq_vector | output | 8 | Vector of the request |
| expire_o | output | 1 | One-cycle expiry strobe |

## Verification
Some properties are checked on every cycle. Delivery gating of the request is one. Another is that a write of the initial count lands in the current count on the next cycle. A third is that the pending count empties and the mask sets while software enable is low. The last two are the one-step decrement on an accepted request and the hold at saturation. Other behaviour can only be shown by the bench's scenarios. These are the exact expiry cycle for each divide code, including the ignored bit 2, and the reload of periodic mode against the stop of one-shot mode. The scenarios also cover the effect of a divisor change in mid-count on the read-back count, and the pending count surviving 300 expiries as exactly 255.

// File: rtl/lpit_pkg.sv
package lpit_pkg;
  localparam int OFF_W   = 4;
  localparam int VEC_W   = 8;
  localparam int SHIFT_W = 3;

  localparam logic [OFF_W-1:0] OFF_ENTRY = 4'h0;
  localparam logic [OFF_W-1:0] OFF_INIT  = 4'h4;
  localparam logic [OFF_W-1:0] OFF_CUR   = 4'h8;
  localparam logic [OFF_W-1:0] OFF_DIV   = 4'hC;

  localparam int ENT_DS_BIT   = 12;
  localparam int ENT_MASK_BIT = 16;
  localparam int ENT_PER_BIT  = 17;

  typedef struct packed {
    logic             periodic;
    logic             masked;
    logic             dstat;
    logic [VEC_W-1:0] vec;
  } entry_t;

  // Divide code to shift amount: three chosen bits plus one, modulo 8.
  function automatic logic [SHIFT_W-1:0] div_shift(input logic [3:0] code);
    return {code[3], code[1], code[0]} + 3'd1;
  endfunction

  function automatic logic [31:0] entry_word(input entry_t e);
    logic [31:0] w;
    w = '0;
    w[VEC_W-1:0]   = e.vec;
    w[ENT_DS_BIT]  = e.dstat;
    w[ENT_MASK_BIT] = e.masked;
    w[ENT_PER_BIT] = e.periodic;
    return w;
  endfunction
endpackage

// File: rtl/lpit_regs.sv
module lpit_regs
  import lpit_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sw_enable,
  input  logic              wr_en,
  input  logic [OFF_W-1:0]  wr_off,
  input  logic [DATA_W-1:0] wr_data,
  output entry_t            entry_q,
  output logic [CNT_W-1:0]  init_q,
  output logic [3:0]        divcfg_q,
  output logic              init_wr
);
  assign init_wr = wr_en && (wr_off == OFF_INIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      entry_q  <= '{periodic: 1'b0, masked: 1'b1, dstat: 1'b0, vec: '0};
      init_q   <= '0;
      divcfg_q <= '0;
    end else begin
      if (wr_en) begin
        case (wr_off)
          OFF_ENTRY: entry_q <= '{periodic: wr_data[ENT_PER_BIT],
                                  masked:   wr_data[ENT_MASK_BIT] | ~sw_enable,
                                  dstat:    wr_data[ENT_DS_BIT],
                                  vec:      wr_data[VEC_W-1:0]};
          OFF_INIT:  init_q   <= wr_data[CNT_W-1:0];
          OFF_DIV:   divcfg_q <= wr_data[3:0];
          default:   ;
        endcase
      end
      if (!sw_enable) entry_q.masked <= 1'b1;
    end
  end
endmodule

// File: rtl/lpit_prescaler.sv
module lpit_prescaler
  import lpit_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               run,
  input  logic               restart,
  input  logic [SHIFT_W-1:0] shift,
  output logic               step
);
  localparam int PRE_W = (1 << SHIFT_W) - 1;

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W:0]   lim;

  assign lim  = ({{PRE_W{1'b0}}, 1'b1} << shift) - 1'b1;
  assign step = run && !restart && ({1'b0, pre_q} >= lim);

  always_ff @(posedge clk) begin
    if (rst || restart || !run || step) pre_q <= '0;
    else                                pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/lpit_counter.sv
module lpit_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] reload_val,
  input  logic             periodic,
  input  logic             step,
  output logic [CNT_W-1:0] cur_q,
  output logic             expire_q,
  output logic             running
);
  assign running = (cur_q != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q    <= '0;
      expire_q <= 1'b0;
    end else if (load) begin
      cur_q    <= load_val;
      expire_q <= 1'b0;
    end else if (step && running) begin
      if (cur_q == CNT_W'(1)) begin
        expire_q <= 1'b1;
        cur_q    <= periodic ? reload_val : '0;
      end else begin
        expire_q <= 1'b0;
        cur_q    <= cur_q - 1'b1;
      end
    end else begin
      expire_q <= 1'b0;
    end
  end
endmodule

// File: rtl/lpit_pending.sv
module lpit_pending #(
  parameter int PEND_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              inc,
  input  logic              deliver_ok,
  input  logic              take,
  output logic              irq_req,
  output logic [PEND_W-1:0] pend_q
);
  localparam logic [PEND_W-1:0] PEND_MAX = '1;

  logic dec;
  assign irq_req = deliver_ok && (pend_q != '0);
  assign dec     = irq_req && take;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      pend_q <= '0;
    end else begin
      case ({inc, dec})
        2'b10:   if (pend_q != PEND_MAX) pend_q <= pend_q + 1'b1;
        2'b01:   pend_q <= pend_q - 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/lpit_timer.sv
module lpit_timer
  import lpit_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32,
  parameter int PEND_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hw_enable,
  input  logic              sw_enable,
  input  logic              wr_en,
  input  logic [OFF_W-1:0]  wr_off,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [OFF_W-1:0]  rd_off,
  output logic [DATA_W-1:0] rd_data,
  input  logic              irq_take,
  output logic              irq_req,
  output logic [VEC_W-1:0]  irq_vector,
  output logic              expire_o
);
  entry_t             entry_q;
  logic [CNT_W-1:0]   init_q;
  logic [3:0]         divcfg_q;
  logic               init_wr;
  logic               step;
  logic               running;
  logic [CNT_W-1:0]   cur_q;
  logic               expire_q;
  logic [PEND_W-1:0]  pend_q;
  logic               ent_masked;
  logic               deliver_ok;

  lpit_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst), .sw_enable(sw_enable),
    .wr_en(wr_en), .wr_off(wr_off), .wr_data(wr_data),
    .entry_q(entry_q), .init_q(init_q), .divcfg_q(divcfg_q), .init_wr(init_wr)
  );

  lpit_prescaler u_pre (
    .clk(clk), .rst(rst), .run(running), .restart(init_wr),
    .shift(div_shift(divcfg_q)), .step(step)
  );

  lpit_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .load(init_wr), .load_val(wr_data[CNT_W-1:0]),
    .reload_val(init_q), .periodic(entry_q.periodic), .step(step),
    .cur_q(cur_q), .expire_q(expire_q), .running(running)
  );

  assign ent_masked = entry_q.masked;
  assign deliver_ok = hw_enable && sw_enable && !ent_masked;

  lpit_pending #(.PEND_W(PEND_W)) u_pend (
    .clk(clk), .rst(rst), .clear(!sw_enable), .inc(expire_q),
    .deliver_ok(deliver_ok), .take(irq_take),
    .irq_req(irq_req), .pend_q(pend_q)
  );

  assign irq_vector = entry_q.vec;
  assign expire_o   = expire_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (rd_en) begin
      case (rd_off)
        OFF_ENTRY: rd_data <= DATA_W'(entry_word(entry_q));
        OFF_INIT:  rd_data <= DATA_W'(init_q);
        OFF_CUR:   rd_data <= DATA_W'(cur_q);
        OFF_DIV:   rd_data <= DATA_W'(divcfg_q);
        default:   rd_data <= '0;
      endcase
    end
  end
endmodule

// File: rtl/lpit_timer_chk.sv
module lpit_timer_chk #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32,
  parameter int PEND_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              hw_enable,
  input logic              sw_enable,
  input logic              wr_en,
  input logic [3:0]        wr_off,
  input logic [DATA_W-1:0] wr_data,
  input logic              irq_take,
  input logic              irq_req,
  input logic              masked,
  input logic              expire,
  input logic [CNT_W-1:0]  cur,
  input logic [PEND_W-1:0] pend
);
  localparam logic [PEND_W-1:0] PMAX = '1;

  p_req_gated_r10: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> (hw_enable && sw_enable && !masked && pend != '0));

  p_take_dec_r10: assert property (@(posedge clk) disable iff (rst)
    (irq_req && irq_take && !expire) |=> (pend == $past(pend) - 1'b1));

  p_no_overflow_r11: assert property (@(posedge clk) disable iff (rst)
    (pend == PMAX && expire && !irq_take && sw_enable) |=> (pend == PMAX));

  p_swdis_clear_r9: assert property (@(posedge clk) disable iff (rst)
    !sw_enable |=> (pend == '0 && masked));

  p_restart_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_off == 4'h4) |=> (cur == $past(wr_data[CNT_W-1:0])));
endmodule

bind lpit_timer lpit_timer_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W), .PEND_W(PEND_W)) u_chk (
  .clk(clk), .rst(rst), .hw_enable(hw_enable), .sw_enable(sw_enable),
  .wr_en(wr_en), .wr_off(wr_off), .wr_data(wr_data), .irq_take(irq_take),
  .irq_req(irq_req), .masked(ent_masked), .expire(expire_q),
  .cur(cur_q), .pend(pend_q)
);

// File: tb/sim_lpit_timer.sv
module sim_lpit_timer;
  logic clk = 1'b0, rst = 1'b1;
  logic hw_enable = 1'b1, sw_enable = 1'b1;
  logic wr_en = 1'b0, rd_en = 1'b0, irq_take = 1'b0;
  logic [3:0] wr_off = '0, rd_off = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic irq_req, expire_o;
  logic [7:0] irq_vector;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  lpit_timer u0 (
    .clk(clk), .rst(rst), .hw_enable(hw_enable), .sw_enable(sw_enable),
    .wr_en(wr_en), .wr_off(wr_off), .wr_data(wr_data),
    .rd_en(rd_en), .rd_off(rd_off), .rd_data(rd_data),
    .irq_take(irq_take), .irq_req(irq_req), .irq_vector(irq_vector),
    .expire_o(expire_o)
  );

  // {divide code, initial count, expected cycles to expiry}
  localparam logic [35:0] VEC_TAB [8] = '{
    {4'b0000, 16'd5, 16'd10},
    {4'b1011, 16'd9, 16'd9},
    {4'b0001, 16'd3, 16'd12},
    {4'b0011, 16'd2, 16'd32},
    {4'b1010, 16'd2, 16'd256},
    {4'b0100, 16'd4, 16'd8},
    {4'b1000, 16'd1, 16'd32},
    {4'b1001, 16'd1, 16'd64}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // All tasks start and end just after a falling edge.
  task automatic wr(input logic [3:0] off, input logic [31:0] d);
    wr_en = 1'b1; wr_off = off; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] off, output logic [31:0] v);
    rd_en = 1'b1; rd_off = off;
    @(negedge clk);
    rd_en = 1'b0;
    v = rd_data;
  endtask

  task automatic measure(output int k);
    k = 0;
    for (int i = 0; i < 2000; i++) begin
      @(posedge clk); k++;
      @(negedge clk);
      if (expire_o) break;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (300000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int k, seen;
    idle(3);
    rst = 1'b0;
    idle(1);

    // Reset state
    rd(4'h0, v); chk("R8 reset entry", v, 32'h0001_0000);
    rd(4'h8, v); chk("R4 reset count", v, 32'h0);
    chk("R10 reset req", {31'b0, irq_req}, 32'h0);

    // Table walk: decode and period
    for (int i = 0; i < 8; i++) begin
      wr(4'hC, {28'b0, VEC_TAB[i][35:32]});
      wr(4'h4, {16'b0, VEC_TAB[i][31:16]});
      measure(k);
      chk($sformatf("R1 R2 period code=%b", VEC_TAB[i][35:32]), k, {16'b0, VEC_TAB[i][15:0]});
    end

    // R8 field masking
    wr(4'h0, 32'hFFFF_FFFF);
    rd(4'h0, v); chk("R8 entry fields", v, 32'h0003_10FF);

    // R7 current count read, divide by 1
    wr(4'hC, 32'hB);
    wr(4'h0, 32'h0001_0000);
    wr(4'h4, 32'd100);
    rd(4'h8, v); chk("R7 count start", v, 32'd100);
    idle(10);
    rd(4'h8, v); chk("R7 count later", v, 32'd89);

    // R6 divisor change in mid-count
    wr(4'h4, 32'd1000);
    wr(4'hC, 32'h1);
    idle(19);
    rd(4'h8, v); chk("R6 divisor change", v, 32'd995);

    // R4 zero initial count
    wr(4'h4, 32'd0);
    seen = 0;
    for (int i = 0; i < 40; i++) begin @(negedge clk); if (expire_o) seen++; end
    chk("R4 no expiry", seen, 0);
    rd(4'h8, v); chk("R4 count zero", v, 32'd0);

    // R3 restart
    wr(4'hC, 32'hB);
    wr(4'h4, 32'd50);
    idle(10);
    wr(4'h4, 32'd6);
    measure(k); chk("R3 restart period", k, 6);

    // R5 periodic then one-shot
    wr(4'h0, 32'h0003_0000);
    wr(4'h4, 32'd7);
    measure(k); chk("R5 periodic first", k, 7);
    measure(k); chk("R5 periodic second", k, 7);
    wr(4'h0, 32'h0001_0000);
    wr(4'h4, 32'd3);
    measure(k); chk("R5 one-shot", k, 3);
    seen = 0;
    for (int i = 0; i < 30; i++) begin @(negedge clk); if (expire_o) seen++; end
    chk("R5 one-shot stops", seen, 0);
    rd(4'h8, v); chk("R5 one-shot count", v, 32'd0);

    // R10 delivery gating and take
    sw_enable = 1'b0; idle(2); sw_enable = 1'b1;
    wr(4'h0, 32'h0001_0045);
    wr(4'h4, 32'd2); measure(k);
    wr(4'h4, 32'd2); measure(k);
    idle(2);
    chk("R10 masked no req", {31'b0, irq_req}, 32'h0);
    wr(4'h0, 32'h0000_0045);
    chk("R10 req unmasked", {31'b0, irq_req}, 32'h1);
    chk("R10 vector", {24'b0, irq_vector}, 32'h45);
    hw_enable = 1'b0; #1;
    chk("R10 hw gate", {31'b0, irq_req}, 32'h0);
    hw_enable = 1'b1;
    @(negedge clk);
    irq_take = 1'b1; @(negedge clk); irq_take = 1'b0;
    chk("R10 one left", {31'b0, irq_req}, 32'h1);
    irq_take = 1'b1; @(negedge clk); irq_take = 1'b0;
    chk("R10 drained", {31'b0, irq_req}, 32'h0);

    // R9 software disable
    wr(4'h4, 32'd2); measure(k); idle(2);
    chk("R9 pre req", {31'b0, irq_req}, 32'h1);
    sw_enable = 1'b0;
    wr(4'h0, 32'h0002_0045);
    sw_enable = 1'b1;
    @(negedge clk);
    chk("R9 pending cleared", {31'b0, irq_req}, 32'h0);
    rd(4'h0, v); chk("R9 mask forced", v, 32'h0003_0045);

    // R11 saturation
    wr(4'h0, 32'h0003_0000);
    wr(4'h4, 32'd1);
    idle(300);
    wr(4'h4, 32'd0);
    idle(2);
    wr(4'h0, 32'h0000_0000);
    irq_take = 1'b1;
    idle(254);
    chk("R11 still pending after 254", {31'b0, irq_req}, 32'h1);
    @(negedge clk);
    chk("R11 empty after 255", {31'b0, irq_req}, 32'h0);
    irq_take = 1'b0;

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule